// File: doc/BRIEF.md
# No-Wait Pipelined Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM whose read and write transfers share one data path. A new command can be issued on every clock, and the data path never needs an idle cycle when it turns from reading to writing or back. Every control and address input is registered on the rising clock edge. For a write, the write data follows its command by the same two-cycle lag that read data has. Because of that matched lag, a read-then-write or write-then-read sequence keeps the data path busy every cycle.

A command is either a load or an advance. A load carries a fresh address and starts a read, a write or a deselect. An advance continues the current operation at the next address of a four-beat burst. That address comes from a 2-bit beat counter combined with the starting address, in linear or interleaved order. An active-low clock enable freezes the whole pipeline. Three chip selects must all be active for a load to select the array. Per-lane write enables mask 9-bit lanes of each written word. The data path is split into an input bus, an output bus and an output-enable flag, which together model one shared tri-state bus.

Top module: `nwb_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `dq_oe` = 0, `dq_out` = 0 and no command in flight.
- R2: A selected load with `adv` = 0 and `wr_n` = 1 is a read. After the second enabled rising edge that follows its command edge, `dq_out` holds the addressed word and `dq_oe` = 1.
- R3: A selected load with `adv` = 0 and `wr_n` = 0 is a write. Its data is taken from `dq_in` at the second enabled edge after the command. Lane i is bits [9i+8:9i] and is written only when `lane_wr_n[i]` was 0 at the command edge; the other lanes keep their stored value. Each burst beat uses the mask sampled with that beat.
- R4: A read may be issued on the cycle right after a write, and a write right after a read, with no idle cycle. A read issued right after a write to the same address returns the newly merged word.
- R5: A load with `order_ilv` = 0 selects linear order. Beat n of the burst (n = 0..3, counted by advances, wrapping after 4) addresses {start[AW-1:2], (start[1:0] + n) mod 4}.
- R6: A load with `order_ilv` = 1 selects interleaved order. Beat n addresses {start[AW-1:2], start[1:0] XOR n}.
- R7: A load selects the array only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. Any other combination is a deselect: nothing is written, no read data is driven, and advances after a deselect stay deselected.
- R8: At a rising edge with `clk_en_n` = 1, all inputs including `dq_in` are ignored, and `dq_out`, `dq_oe` and every internal register keep their values.
- R9: `dq_oe` is 0 after the data edge of a write and after the data edge of a deselect.
- R10: An advance keeps the operation type and selection of the burst. During an advance, `wr_n` and the three chip selects are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| adv | input | 1 | 0 = load a new command, 1 = advance the burst |
| wr_n | input | 1 | 0 = write, 1 = read (used on loads) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| order_ilv | input | 1 | Burst order on loads: 1 = interleaved, 0 = linear |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | High while `dq_out` carries read data |

## Verification
The bench builds the block with its defaults: ADDR_W = 6 (64 words), LANES = 4 and LANE_W = 9. With this size the whole array can be filled and read back. The bench starts a burst from every one of the 64 addresses in both linear and interleaved order. It also sweeps all 16 lane masks over write bursts and write-then-read pairs. The same small configuration makes it possible to try each of the eight chip-select combinations and to insert suspend cycles at every pipeline position. Expected data comes from a reference array that is updated arithmetically from the requirements.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   // low two address bits of burst beat `cnt` starting at `start`
   function automatic logic [1:0] beat_lane(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
      return ilv ? (start ^ cnt) : (start + cnt);
   endfunction

endpackage

// File: rtl/nwb_burst_seq.sv
module nwb_burst_seq
   import nwb_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  logic              wr_req,
   input  logic              ilv_in,
   input  logic [ADDR_W-1:0] addr_in,
   output op_e               op,
   output logic [ADDR_W-1:0] addr_out
);

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic              ilv_q;
   op_e               op_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_NONE;
         base_q <= '0;
         cnt_q  <= '0;
         ilv_q  <= 1'b0;
      end else if (en) begin
         if (load) begin
            op_q   <= sel ? (wr_req ? OP_WR : OP_RD) : OP_NONE;
            base_q <= addr_in;
            cnt_q  <= '0;
            ilv_q  <= ilv_in;
         end else if (op_q != OP_NONE) begin
            cnt_q  <= cnt_q + 2'd1;
         end
      end
   end

   assign op = op_q;

   generate
      if (ADDR_W == 2) begin : g_lane_only
         assign addr_out = beat_lane(base_q[1:0], cnt_q, ilv_q);
      end else begin : g_with_row
         assign addr_out = {base_q[ADDR_W-1:2], beat_lane(base_q[1:0], cnt_q, ilv_q)};
      end
   endgenerate

endmodule

// File: rtl/nwb_pipe_stage.sv
module nwb_pipe_stage
   import nwb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  op_e               op_d,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [LANES-1:0]  mask_d,
   output op_e               op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  mask_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_NONE;
         addr_q <= '0;
         mask_q <= '1;
      end else if (en) begin
         op_q   <= op_d;
         addr_q <= addr_d;
         mask_q <= mask_d;
      end
   end

endmodule

// File: rtl/nwb_lane_array.sv
module nwb_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES-1:0]          lane_wr_n,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] cells [DEPTH];

         always_ff @(posedge clk) begin
            if (we && !lane_wr_n[g])
               cells[addr] <= wdata[g*LANE_W +: LANE_W];
         end

         assign rdata[g*LANE_W +: LANE_W] = cells[addr];
      end
   endgenerate

endmodule

// File: rtl/nwb_sram.sv
module nwb_sram
   import nwb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    adv,
   input  logic                    wr_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    order_ilv,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;

   initial begin
      assert (ADDR_W >= 2) else $error("nwb_sram: ADDR_W must cover a 4-beat burst");
      assert (LANES >= 1)  else $error("nwb_sram: LANES must be at least 1");
      assert (LANE_W >= 1) else $error("nwb_sram: LANE_W must be at least 1");
   end

   logic              go;
   logic              chip_sel;
   op_e               s1_op, s2_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s1_mask, s2_mask;
   logic [DATA_W-1:0] rd_word;

   assign go       = !clk_en_n;
   assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

   // stage 1: command decode and burst address
   nwb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (go),
      .load     (!adv),
      .sel      (chip_sel),
      .wr_req   (!wr_n),
      .ilv_in   (order_ilv),
      .addr_in  (addr),
      .op       (s1_op),
      .addr_out (s1_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)  s1_mask <= '1;
      else if (go) s1_mask <= lane_wr_n;
   end

   // stage 2: aligns the command with its data cycle
   nwb_pipe_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_s2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (go),
      .op_d   (s1_op),
      .addr_d (s1_addr),
      .mask_d (s1_mask),
      .op_q   (s2_op),
      .addr_q (s2_addr),
      .mask_q (s2_mask)
   );

   nwb_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk       (clk),
      .we        (go && (s2_op == OP_WR)),
      .addr      (s2_addr),
      .lane_wr_n (s2_mask),
      .wdata     (dq_in),
      .rdata     (rd_word)
   );

   // data cycle: drive read data, release the bus otherwise
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_oe  <= 1'b0;
         dq_out <= '0;
      end else if (go) begin
         dq_oe <= (s2_op == OP_RD);
         if (s2_op == OP_RD) dq_out <= rd_word;
      end
   end

endmodule

module nwb_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              adv,
   input logic              wr_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   logic on;
   assign on = !sel_a_n && sel_b && !sel_c_n;

   // R2
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && on && wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> dq_oe);

   // R9
   write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && on && !wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

   // R7
   deselect_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && !on) ##1 (!clk_en_n && adv) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

   // R10
   read_burst_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && on && wr_n) ##1 (!clk_en_n && adv) ##1 !clk_en_n ##1 !clk_en_n |=> dq_oe);

   // R8
   suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(dq_oe) && $stable(dq_out)));

   // R8
   oe_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> $past(!clk_en_n));

endmodule

bind nwb_sram nwb_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .adv      (adv),
   .wr_n     (wr_n),
   .sel_a_n  (sel_a_n),
   .sel_b    (sel_b),
   .sel_c_n  (sel_c_n),
   .dq_out   (dq_out),
   .dq_oe    (dq_oe)
);

// File: tb/nwb_sram_bench.sv
module nwb_sram_bench;

   localparam int AW    = 6;
   localparam int NL    = 4;
   localparam int LW    = 9;
   localparam int DW    = NL * LW;
   localparam int DEPTH = 1 << AW;
   localparam logic [2:0] CS_ON  = 3'b010;  // {sel_a_n, sel_b, sel_c_n}
   localparam logic [2:0] CS_OFF = 3'b110;

   logic clk = 1'b0;
   always #10 clk = ~clk;  // 20 ns period, 50 MHz

   logic          rst_n, clk_en_n, adv, wr_n, sel_a_n, sel_b, sel_c_n, order_ilv;
   logic [NL-1:0] lane_wr_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_in, dq_out;
   logic          dq_oe;

   nwb_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_nwb_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv(adv), .wr_n(wr_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .order_ilv(order_ilv),
      .lane_wr_n(lane_wr_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   // reference model
   logic [DW-1:0] ref_mem [DEPTH];
   int            q_op [2];   // 0 none, 1 read, 2 write
   int            q_addr [2];
   logic [NL-1:0] q_mask [2];
   int            mb_op, mb_base, mb_cnt, mb_ilv;
   logic          exp_oe;
   logic [DW-1:0] exp_dout;
   int            n_chk = 0, n_fail = 0, tick = 0;
   string         cur_req;

   function automatic logic [DW-1:0] mkdata(input int t);
      logic [63:0] x;
      x = 64'(t) * 64'h9E37_79B9_7F4A_7C15;
      x = x ^ (x >> 29);
      return x[DW-1:0];
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic cke_n_v, input logic adv_v, input logic wr_n_v,
                      input logic [2:0] cs, input logic ilv_v, input int a,
                      input logic [NL-1:0] mask);
      logic [DW-1:0] wd;
      int lo;
      tick++;
      wd = mkdata(tick);
      clk_en_n = cke_n_v; adv = adv_v; wr_n = wr_n_v;
      {sel_a_n, sel_b, sel_c_n} = cs;
      order_ilv = ilv_v; addr = a[AW-1:0]; lane_wr_n = mask; dq_in = wd;
      @(posedge clk);
      if (!cke_n_v) begin
         if (q_op[1] == 2)
            for (int l = 0; l < NL; l++)
               if (!q_mask[1][l]) ref_mem[q_addr[1]][l*LW +: LW] = wd[l*LW +: LW];
         exp_oe = (q_op[1] == 1);
         if (exp_oe) exp_dout = ref_mem[q_addr[1]];
         q_op[1] = q_op[0]; q_addr[1] = q_addr[0]; q_mask[1] = q_mask[0];
         if (!adv_v) begin
            mb_op   = (cs == CS_ON) ? (wr_n_v ? 1 : 2) : 0;
            mb_base = a; mb_cnt = 0; mb_ilv = int'(ilv_v);
         end else if (mb_op != 0) begin
            mb_cnt = (mb_cnt + 1) % 4;
         end
         lo = (mb_ilv != 0) ? ((mb_base % 4) ^ mb_cnt) : ((mb_base % 4 + mb_cnt) % 4);
         q_op[0] = mb_op; q_addr[0] = (mb_base / 4) * 4 + lo; q_mask[0] = mask;
      end
      @(negedge clk);
      chk({cur_req, " dq_oe"}, DW'(dq_oe), DW'(exp_oe));
      if (exp_oe) chk({cur_req, " dq_out"}, dq_out, exp_dout);
   endtask

   task automatic ld(input logic wrn, input int a, input logic ilv, input logic [NL-1:0] mask);
      cyc(1'b0, 1'b0, wrn, CS_ON, ilv, a, mask);
   endtask

   task automatic beat(input logic [NL-1:0] mask);
      cyc(1'b0, 1'b1, 1'b1, CS_ON, 1'b0, 0, mask);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, CS_OFF, 1'b0, 0, '1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; clk_en_n = 1'b0; adv = 1'b0; wr_n = 1'b1;
      {sel_a_n, sel_b, sel_c_n} = CS_OFF; order_ilv = 1'b0;
      lane_wr_n = '1; addr = '0; dq_in = '0;
      q_op[0] = 0; q_op[1] = 0; q_addr[0] = 0; q_addr[1] = 0;
      q_mask[0] = '1; q_mask[1] = '1;
      mb_op = 0; mb_base = 0; mb_cnt = 0; mb_ilv = 0;
      exp_oe = 1'b0; exp_dout = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset dq_oe", DW'(dq_oe), '0);
      chk("R1 reset dq_out", dq_out, '0);
      rst_n = 1'b1;

      // R3: fill every word with full-lane writes
      cur_req = "R3 fill";
      for (int a = 0; a < DEPTH; a++) ld(1'b0, a, 1'b0, '0);
      idle(2);

      // R2: back-to-back single reads of every word
      cur_req = "R2 single read";
      for (int a = 0; a < DEPTH; a++) ld(1'b1, a, 1'b0, '1);
      idle(2);

      // R5: linear read bursts from every start
      cur_req = "R5 linear burst";
      for (int a = 0; a < DEPTH; a++) begin
         ld(1'b1, a, 1'b0, '1);
         for (int b = 0; b < 3; b++) beat('1);
      end
      idle(2);

      // R6: interleaved read bursts from every start
      cur_req = "R6 interleaved burst";
      for (int a = 0; a < DEPTH; a++) begin
         ld(1'b1, a, 1'b1, '1);
         for (int b = 0; b < 3; b++) beat('1);
      end
      idle(2);

      // R3: masked write bursts, every mask, then read back with wrap past 4 beats
      cur_req = "R3 masked write burst";
      for (int a = 0; a < DEPTH; a += 3) begin
         ld(1'b0, a, a[0], NL'(a % 16));
         for (int b = 1; b < 4; b++) beat(NL'((a + b) % 16));
         ld(1'b1, a, a[0], '1);
         for (int b = 1; b < 6; b++) beat('1);
      end
      idle(2);

      // R4/R9: write then read of the same word, no idle between
      cur_req = "R4/R9 turnaround";
      for (int a = 0; a < DEPTH; a++) begin
         ld(1'b0, a, 1'b0, NL'((a * 7) % 16));
         ld(1'b1, a, 1'b0, '1);
      end
      idle(2);

      // R7: every non-selecting chip-select combination attempts a write burst
      cur_req = "R7 deselect";
      for (int c = 0; c < 8; c++) begin
         if (3'(c) != CS_ON) begin
            cyc(1'b0, 1'b0, 1'b0, 3'(c), 1'b0, 40 + c, '0);
            cyc(1'b0, 1'b1, 1'b0, CS_ON, 1'b0, 0, '0);
            cyc(1'b0, 1'b1, 1'b0, CS_ON, 1'b0, 0, '0);
            idle(2);
            ld(1'b1, 40 + c, 1'b0, '1);
            ld(1'b1, 41 + c, 1'b0, '1);
            idle(2);
         end
      end

      // R8: suspend cycles inside a read burst carrying a garbage write command
      cur_req = "R8 suspend";
      ld(1'b1, 9, 1'b0, '1);
      cyc(1'b1, 1'b0, 1'b0, CS_ON, 1'b0, 20, '0);
      beat('1);
      cyc(1'b1, 1'b0, 1'b0, CS_ON, 1'b0, 21, '0);
      cyc(1'b1, 1'b0, 1'b0, CS_ON, 1'b0, 22, '0);
      beat('1);
      beat('1);
      cyc(1'b1, 1'b0, 1'b0, CS_ON, 1'b0, 23, '0);
      idle(2);
      for (int a = 20; a < 24; a++) ld(1'b1, a, 1'b0, '1);
      idle(2);
      // R8: suspend between a write command and its data edge
      ld(1'b0, 30, 1'b0, 4'b0101);
      cyc(1'b1, 1'b1, 1'b1, CS_OFF, 1'b0, 0, '0);
      cyc(1'b1, 1'b0, 1'b0, CS_ON, 1'b0, 31, '0);
      idle(2);
      ld(1'b1, 30, 1'b0, '1);
      ld(1'b1, 31, 1'b0, '1);
      idle(2);

      // R10: advances ignore wr_n and chip selects
      cur_req = "R10 advance keeps type";
      ld(1'b1, 12, 1'b0, '1);
      for (int b = 0; b < 3; b++) cyc(1'b0, 1'b1, 1'b0, CS_OFF, 1'b1, 50, '0);
      ld(1'b0, 16, 1'b1, '0);
      for (int b = 0; b < 3; b++) cyc(1'b0, 1'b1, 1'b1, 3'b101, 1'b0, 60, 4'b0011);
      ld(1'b1, 16, 1'b1, '1);
      for (int b = 0; b < 3; b++) beat('1);
      idle(3);

      summary();
      $finish;
   end

endmodule